// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block carries 36-bit words from a producer on one clock to a consumer on an unrelated clock. Both clocks run freely and may be fully asynchronous or identical. The write side only ever sees a full indication and an almost-full threshold, each computed in its own clock. The read side only sees an empty or word-valid indication and an almost-empty threshold, computed in the read clock. Read and write pointers cross between the domains as Gray codes through two-flop synchronizers.

Two read disciplines are available, chosen while full reset is held. In standard mode a read request pops the next word into the output register. In fall-through mode the head word sits on the output by itself and a read request consumes it. Each threshold flag has its own offset. The offsets come from one of three fixed presets, from a serial bit stream, or from two special parallel writes; the choice is made during full reset. A partial reset empties the queue but leaves mode and offsets as they are.

Top module: `afifo_progflag`

## Requirements
- R1: Every accepted word leaves the read port unaltered (all 36 bits), in write order, in both read disciplines, with independent clocks.
- R2: Standard mode (`cfg_fwft`=0 during full reset): `rd_flag`=1 means empty. A rising `rclk` edge with `rd_en`=1 and `rd_flag`=0 places the next word on `rd_data` after that edge. `rd_data` holds otherwise. `wr_flag`=1 means full.
- R3: A write while the queue has no room, or a read while it holds no word, is ignored: stored contents, order and `rd_data` are unchanged.
- R4: In standard mode `wr_flag` rises after exactly 2^AW accepted words (256 by default). After reset the flags read empty=1, full=0, almost-empty=1, almost-full=0.
- R5: Fall-through mode (`cfg_fwft`=1): `rd_flag`=1 means a valid word is on `rd_data`, and the first word appears there without any read request. `rd_en` consumes it. `wr_flag`=1 means room to write. The capacity is 2^AW+1 words.
- R6: `almost_empty`=1 exactly when the stored word count (including the fall-through output word) is at or below the almost-empty offset.
- R7: `almost_full`=1 exactly when 2^AW minus the words held in memory (excluding the fall-through output word) is at or below the almost-full offset.
- R8: While full reset is held, `cfg_preset` = 01, 10 or 11 sets both offsets to 8, 16 or 64 respectively.
- R9: With `cfg_preset`=00 and `cfg_serial`=1, each `wclk` edge with `ser_en`=1 shifts in one bit of `ser_din`, 2*AW bits in total. The almost-empty offset comes first, then the almost-full offset, each most significant bit first. Both take effect after the last bit, and later bits are ignored.
- R10: With `cfg_preset`=00 and `cfg_serial`=0, a write with `prog_en`=1 loads `wr_data[AW-1:0]`, alternately into the almost-empty and then the almost-full offset. Such writes never store a word.
- R11: Partial reset (`prst_n` low) empties the queue and keeps the read discipline, the programming mode and both offsets.
- R12: Full reset (`rst_n` low) empties the queue and resamples the configuration pins. The two programmable modes start with both offsets at 8.
- R13: Reads and writes issued together on both clocks all complete, with no word lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low; configuration pins are sampled while low |
| prst_n | input | 1 | Partial reset, active low; keeps configuration |
| cfg_fwft | input | 1 | 1 selects fall-through read discipline (sampled in full reset) |
| cfg_preset | input | 2 | Offset preset: 00 programmable, 01/10/11 = 8/16/64 |
| cfg_serial | input | 1 | With preset 00: 1 serial, 0 parallel offset loading |
| wr_en | input | 1 | Write request |
| prog_en | input | 1 | Marks a write as an offset load rather than data |
| wr_data | input | 36 | Write word |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset bit |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read word |
| rd_flag | output | 1 | Empty (standard) or word valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or room available (fall-through) |
| almost_empty | output | 1 | Word count at or below its offset |
| almost_full | output | 1 | Free space at or below its offset |

## Verification
The hazardous overlap is a push on `wclk` and a pop on `rclk` that hit the same stored word as the level crosses zero or capacity. The bench provokes this by running write and read bursts concurrently on two clocks of different periods, starting from a few stored words so that the queue repeatedly drains and refills. Every popped word is compared against the scoreboard queue filled by the write driver, so a lost, doubled or reordered word is reported. The four flags are then compared with the level the scoreboard holds once both synchronizers have settled.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic [1:0] {
        PM_FIXED    = 2'd0,
        PM_SERIAL   = 2'd1,
        PM_PARALLEL = 2'd2
    } prog_mode_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign dout = sync_q.s2;
endmodule

// File: rtl/afifo_cfg.sv
module afifo_cfg
    import afifo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          fwft_pin,
    input  logic [1:0]    preset_pin,
    input  logic          serial_pin,
    input  logic          wr_en,
    input  logic          prog_en,
    input  logic [AW-1:0] pdata,
    input  logic          ser_en,
    input  logic          ser_din,
    output logic          fwft,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    localparam int SW = 2 * AW;
    localparam int CW = $clog2(SW + 1);

    typedef struct packed {
        prog_mode_e    mode;
        logic          fwft;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
        logic [SW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          psel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.fwft = fwft_pin;
            cfg_d.sh   = '0;
            cfg_d.cnt  = '0;
            cfg_d.psel = 1'b0;
            cfg_d.mode = PM_FIXED;
            case (preset_pin)
                2'b01: begin cfg_d.ae = AW'(8);  cfg_d.af = AW'(8);  end
                2'b10: begin cfg_d.ae = AW'(16); cfg_d.af = AW'(16); end
                2'b11: begin cfg_d.ae = AW'(64); cfg_d.af = AW'(64); end
                default: begin
                    cfg_d.mode = serial_pin ? PM_SERIAL : PM_PARALLEL;
                    cfg_d.ae   = AW'(8);
                    cfg_d.af   = AW'(8);
                end
            endcase
        end else begin
            case (cfg_q.mode)
                PM_SERIAL: begin
                    if (ser_en && cfg_q.cnt != CW'(SW)) begin
                        cfg_d.sh  = {cfg_q.sh[SW-2:0], ser_din};
                        cfg_d.cnt = cfg_q.cnt + CW'(1);
                        if (cfg_q.cnt == CW'(SW - 1)) begin
                            cfg_d.ae = cfg_d.sh[SW-1:AW];
                            cfg_d.af = cfg_d.sh[AW-1:0];
                        end
                    end
                end
                PM_PARALLEL: begin
                    if (wr_en && prog_en) begin
                        if (cfg_q.psel) cfg_d.af = pdata;
                        else            cfg_d.ae = pdata;
                        cfg_d.psel = !cfg_q.psel;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge wclk) begin
        cfg_q <= cfg_d;
    end

    assign fwft   = cfg_q.fwft;
    assign ae_off = cfg_q.ae;
    assign af_off = cfg_q.af;

    AST_MODE_KEPT: assert property (@(posedge wclk) disable iff (!rst_n)
        rst_n |=> ($stable(cfg_q.mode) && $stable(cfg_q.fwft))); // R11
    AST_SER_LIMIT: assert property (@(posedge wclk) disable iff (!rst_n)
        cfg_q.cnt <= CW'(SW)); // R9
endmodule

// File: rtl/afifo_wr.sv
module afifo_wr
    import afifo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          arst_n,
    input  logic          wr_en,
    input  logic          prog_en,
    input  logic [AW:0]   rq_gray,
    input  logic [AW-1:0] af_off,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          push,
    output logic          full,
    output logic          afull
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
    } wst_t;

    wst_t w_d, w_q;
    logic [PW-1:0] rq_bin, bin_n, lvl_n, free_n;

    always_comb begin
        w_d    = w_q;
        push   = wr_en && !prog_en && !w_q.full;
        rq_bin = PW'(gray2bin(32'(rq_gray)));
        bin_n  = w_q.bin + PW'(push);
        lvl_n  = bin_n - rq_bin;
        free_n = DEPTH_P - lvl_n;
        w_d.bin   = bin_n;
        w_d.gray  = PW'(bin2gray(32'(bin_n)));
        w_d.full  = (lvl_n == DEPTH_P);
        w_d.afull = (free_n <= PW'(af_off));
    end

    always_ff @(posedge wclk or negedge arst_n) begin
        if (!arst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    assign waddr = w_q.bin[AW-1:0];
    assign wgray = w_q.gray;
    assign full  = w_q.full;
    assign afull = w_q.afull;

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!arst_n)
        (w_q.full && wr_en) |=> $stable(w_q.bin)); // R3
    AST_LEVEL_BOUND: assert property (@(posedge wclk) disable iff (!arst_n)
        (w_q.bin - rq_bin) <= DEPTH_P); // R4
    AST_GRAY_STEP_W: assert property (@(posedge wclk) disable iff (!arst_n)
        $countones(w_q.gray ^ $past(w_q.gray)) <= 1); // R13
endmodule

// File: rtl/afifo_rd.sv
module afifo_rd
    import afifo_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          rclk,
    input  logic          arst_n,
    input  logic          rd_en,
    input  logic          fwft,
    input  logic [AW-1:0] ae_off,
    input  logic [AW:0]   wq_gray,
    input  logic [DW-1:0] mem_word,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          aempty
);
    localparam int PW = AW + 1;
    localparam int CW = AW + 2;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [DW-1:0] data;
        logic          oval;
        logic          empty;
        logic          aempty;
    } rst_t;

    localparam rst_t R_RST = '{bin: '0, gray: '0, data: '0,
                               oval: 1'b0, empty: 1'b1, aempty: 1'b1};

    rst_t r_d, r_q;
    logic [PW-1:0] wq_bin, ram_lvl, ram_n, bin_n;
    logic [CW-1:0] cnt_n;
    logic          take, load, oval_n;

    always_comb begin
        r_d     = r_q;
        wq_bin  = PW'(gray2bin(32'(wq_gray)));
        ram_lvl = wq_bin - r_q.bin;
        if (fwft) begin
            take   = rd_en && r_q.oval;
            load   = (ram_lvl != '0) && (!r_q.oval || take);
            oval_n = load || (r_q.oval && !take);
        end else begin
            take   = 1'b0;
            load   = rd_en && !r_q.empty;
            oval_n = 1'b0;
        end
        bin_n      = r_q.bin + PW'(load);
        ram_n      = wq_bin - bin_n;
        cnt_n      = CW'(ram_n) + CW'(oval_n);
        r_d.bin    = bin_n;
        r_d.gray   = PW'(bin2gray(32'(bin_n)));
        r_d.data   = load ? mem_word : r_q.data;
        r_d.oval   = oval_n;
        r_d.empty  = (ram_n == '0);
        r_d.aempty = (cnt_n <= CW'(ae_off));
    end

    always_ff @(posedge rclk or negedge arst_n) begin
        if (!arst_n) r_q <= R_RST;
        else         r_q <= r_d;
    end

    assign raddr   = r_q.bin[AW-1:0];
    assign rgray   = r_q.gray;
    assign rd_data = r_q.data;
    assign rd_flag = fwft ? r_q.oval : r_q.empty;
    assign aempty  = r_q.aempty;

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!arst_n)
        (!fwft && r_q.empty && rd_en) |=> ($stable(r_q.bin) && $stable(r_q.data))); // R3
    AST_EMPTY_AE: assert property (@(posedge rclk) disable iff (!arst_n)
        (!fwft && r_q.empty) |-> r_q.aempty); // R6
    AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (!arst_n)
        (fwft && r_q.oval && !rd_en) |=> (r_q.oval && $stable(r_q.data))); // R5
    AST_GRAY_STEP_R: assert property (@(posedge rclk) disable iff (!arst_n)
        $countones(r_q.gray ^ $past(r_q.gray)) <= 1); // R13
endmodule

// File: rtl/afifo_progflag.sv
module afifo_progflag
    import afifo_pkg::*;
#(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic [1:0]    cfg_preset,
    input  logic          cfg_serial,
    input  logic          wr_en,
    input  logic          prog_en,
    input  logic [DW-1:0] wr_data,
    input  logic          ser_en,
    input  logic          ser_din,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          wr_flag,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int DEPTH = 1 << AW;

    logic          arst_n;
    logic          fwft, push, full;
    logic [AW-1:0] ae_off, af_off, waddr, raddr;
    logic [AW:0]   wgray, rgray, wq_gray, rq_gray;
    logic [DW-1:0] mem_word;
    logic [DW-1:0] mem [DEPTH];

    assign arst_n = rst_n && prst_n;

    afifo_cfg #(.AW(AW)) u_cfg (
        .wclk(wclk), .rst_n(rst_n), .fwft_pin(cfg_fwft), .preset_pin(cfg_preset),
        .serial_pin(cfg_serial), .wr_en(wr_en), .prog_en(prog_en),
        .pdata(wr_data[AW-1:0]), .ser_en(ser_en), .ser_din(ser_din),
        .fwft(fwft), .ae_off(ae_off), .af_off(af_off)
    );

    afifo_wr #(.AW(AW)) u_wr (
        .wclk(wclk), .arst_n(arst_n), .wr_en(wr_en), .prog_en(prog_en),
        .rq_gray(rq_gray), .af_off(af_off), .waddr(waddr), .wgray(wgray),
        .push(push), .full(full), .afull(almost_full)
    );

    afifo_sync #(.W(AW + 1)) u_sync_r2w (
        .clk(wclk), .arst_n(arst_n), .din(rgray), .dout(rq_gray)
    );

    afifo_sync #(.W(AW + 1)) u_sync_w2r (
        .clk(rclk), .arst_n(arst_n), .din(wgray), .dout(wq_gray)
    );

    always_ff @(posedge wclk) begin
        if (push) mem[waddr] <= wr_data;
    end

    assign mem_word = mem[raddr];

    afifo_rd #(.DW(DW), .AW(AW)) u_rd (
        .rclk(rclk), .arst_n(arst_n), .rd_en(rd_en), .fwft(fwft),
        .ae_off(ae_off), .wq_gray(wq_gray), .mem_word(mem_word),
        .raddr(raddr), .rgray(rgray), .rd_data(rd_data),
        .rd_flag(rd_flag), .aempty(almost_empty)
    );

    assign wr_flag = fwft ? !full : full;
endmodule

// File: tb/tb_afifo_progflag.sv
`timescale 1ns/1ps
module tb_afifo_progflag;
    localparam int DW = 36;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic wclk = 0, rclk = 0;
    logic rst_n = 0, prst_n = 1;
    logic cfg_fwft = 0, cfg_serial = 0;
    logic [1:0] cfg_preset = 2'b01;
    logic wr_en = 0, prog_en = 0, ser_en = 0, ser_din = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_flag, wr_flag, almost_empty, almost_full;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    afifo_progflag #(.DW(DW), .AW(AW)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_preset(cfg_preset), .cfg_serial(cfg_serial),
        .wr_en(wr_en), .prog_en(prog_en), .wr_data(wr_data),
        .ser_en(ser_en), .ser_din(ser_din), .rd_en(rd_en),
        .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] exp_q[$];
    bit tb_fwft = 0;
    int m_ae = 8, m_af = 8;
    int wseq = 0;
    bit pend = 0;

    task automatic check_eq(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pop_cmp(logic [DW-1:0] got);
        if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R1: actual %0h expected no word", got);
        end else begin
            check_eq("R1", 64'(got), 64'(exp_q.pop_front()));
        end
    endtask

    // monitor: pops expected words as the design delivers them
    always @(negedge rclk) begin
        if (!rst_n || !prst_n) begin
            pend = 0;
        end else begin
            if (pend) pop_cmp(rd_data);
            pend = !tb_fwft && rd_en && !rd_flag;
            if (tb_fwft && rd_en && rd_flag) pop_cmp(rd_data);
        end
    end

    task automatic settle();
        repeat (12) @(posedge rclk);
        repeat (12) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic check_flags(string req);
        int q = exp_q.size();
        int ram = tb_fwft ? ((q > 0) ? q - 1 : 0) : q;
        check_eq(req, 64'(rd_flag), tb_fwft ? 64'(q > 0) : 64'(q == 0));
        check_eq(req, 64'(wr_flag), tb_fwft ? 64'(ram < DEPTH) : 64'(q == DEPTH));
        check_eq(req, 64'(almost_empty), 64'(q <= m_ae));
        check_eq(req, 64'(almost_full), 64'((DEPTH - ram) <= m_af));
    endtask

    task automatic wr_burst(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge wclk); #1;
            wr_en   = 1;
            wr_data = {4'h5, 32'(wseq * 7919 + 3)};
            if (tb_fwft ? wr_flag : !wr_flag) exp_q.push_back(wr_data);
            wseq++;
        end
        @(posedge wclk); #1;
        wr_en = 0;
    endtask

    task automatic rd_burst(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge rclk); #1;
            rd_en = 1;
        end
        @(posedge rclk); #1;
        rd_en = 0;
    endtask

    task automatic fill_to(int n);
        if (n > exp_q.size()) wr_burst(n - exp_q.size());
        settle();
    endtask

    task automatic drain();
        rd_burst(exp_q.size() + 3);
        settle();
    endtask

    task automatic full_reset(bit fw, logic [1:0] pre, bit ser);
        cfg_fwft = fw; cfg_preset = pre; cfg_serial = ser;
        rst_n = 0;
        repeat (4) @(posedge wclk);
        repeat (2) @(posedge rclk);
        @(posedge wclk); #1;
        rst_n = 1;
        exp_q.delete();
        tb_fwft = fw;
        case (pre)
            2'b10:   begin m_ae = 16; m_af = 16; end
            2'b11:   begin m_ae = 64; m_af = 64; end
            default: begin m_ae = 8;  m_af = 8;  end
        endcase
        settle();
    endtask

    task automatic part_reset();
        prst_n = 0;
        repeat (3) @(posedge wclk);
        repeat (2) @(posedge rclk);
        @(posedge wclk); #1;
        prst_n = 1;
        exp_q.delete();
        settle();
    endtask

    task automatic ser_load(logic [AW-1:0] ae, logic [AW-1:0] af, int extra);
        logic [2*AW-1:0] v = {ae, af};
        for (int i = 2*AW - 1; i >= -extra; i--) begin
            @(posedge wclk); #1;
            ser_en  = 1;
            ser_din = (i >= 0) ? v[i] : 1'b1;
        end
        @(posedge wclk); #1;
        ser_en = 0;
    endtask

    task automatic par_load(logic [AW-1:0] val);
        @(posedge wclk); #1;
        wr_en = 1; prog_en = 1; wr_data = {28'hABCDEF0, val};
        @(posedge wclk); #1;
        wr_en = 0; prog_en = 0;
    endtask

    task automatic run_all();
        logic [DW-1:0] held;
        // standard mode, preset 8
        full_reset(0, 2'b01, 0);
        check_flags("R4");
        check_flags("R12");
        fill_to(5);  check_flags("R6");
        fill_to(8);  check_flags("R6");
        fill_to(9);  check_flags("R6");
        rd_burst(3); settle();
        check_flags("R2");
        drain(); check_flags("R2");
        // almost-full boundary and capacity
        fill_to(DEPTH - 9); check_flags("R7");
        fill_to(DEPTH - 8); check_flags("R7");
        fill_to(DEPTH);     check_flags("R4");
        wr_burst(4); settle();
        check_eq("R3", 64'(exp_q.size()), 64'(DEPTH));
        check_flags("R3");
        drain(); check_flags("R1");
        // reads while empty
        held = rd_data;
        rd_burst(4); settle();
        check_eq("R3", 64'(rd_data), 64'(held));
        fill_to(2); drain(); check_flags("R3");
        // concurrent traffic
        fill_to(6);
        fork
            wr_burst(60);
            rd_burst(70);
        join
        settle(); check_flags("R13");
        drain(); check_flags("R13");
        // presets 16 and 64
        full_reset(0, 2'b10, 0);
        fill_to(16); check_flags("R8");
        fill_to(17); check_flags("R8");
        drain();
        full_reset(0, 2'b11, 0);
        fill_to(64); check_flags("R8");
        fill_to(65); check_flags("R8");
        fill_to(DEPTH - 64); check_flags("R8");
        drain();
        // serial programming
        full_reset(0, 2'b00, 1);
        fill_to(8); check_flags("R12");
        fill_to(9); check_flags("R12");
        drain();
        ser_load(AW'(20), AW'(30), 3);
        m_ae = 20; m_af = 30;
        settle();
        fill_to(20); check_flags("R9");
        fill_to(21); check_flags("R9");
        fill_to(DEPTH - 31); check_flags("R9");
        fill_to(DEPTH - 30); check_flags("R9");
        // partial reset keeps offsets
        part_reset();
        check_flags("R11");
        fill_to(20); check_flags("R11");
        fill_to(21); check_flags("R11");
        drain();
        // parallel programming
        full_reset(0, 2'b00, 0);
        par_load(AW'(5));
        par_load(AW'(3));
        m_ae = 5; m_af = 3;
        settle();
        check_flags("R10");
        fill_to(5); check_flags("R10");
        fill_to(6); check_flags("R10");
        fill_to(DEPTH - 4); check_flags("R10");
        fill_to(DEPTH - 3); check_flags("R10");
        drain();
        // fall-through mode
        full_reset(1, 2'b01, 0);
        check_flags("R5");
        fill_to(3);
        check_flags("R5");
        check_eq("R5", 64'(rd_data), 64'(exp_q[0]));
        rd_burst(1); settle();
        check_eq("R5", 64'(rd_data), 64'(exp_q[0]));
        fill_to(9); check_flags("R6");
        fill_to(10); check_flags("R6");
        wr_burst(DEPTH + 4); settle();
        check_eq("R5", 64'(exp_q.size()), 64'(DEPTH + 1));
        check_flags("R5");
        drain(); check_flags("R5");
        fill_to(4);
        fork
            wr_burst(50);
            rd_burst(52);
        join
        settle(); check_flags("R13");
        part_reset(); check_flags("R11");
        fill_to(1); check_flags("R11");
        drain();
    endtask

    initial begin
        fork
            run_all();
            begin
                #900000;
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule